// File: doc/BRIEF.md
# Oversampling Ratio Detector with Clock Prescaler

This block runs on the system clock. It works out how many system clocks fit into one period of the already synchronized word clock, and from that the integer factor `n` that sets the noise-shaper rate. No register has to be programmed. A pin selects whether the system clock is used as it is or halved first. A second pin says whether the incoming samples are 8x or 4x oversampled, and this sets the range of `n` that is accepted.

One "unit" is 8 internal clocks. That is 8 system clocks when the prescaler is bypassed and 16 when it halves. A word period of P system clocks is accepted when P is an exact multiple of the unit and P/unit lies in the legal range. Once the same accepted period is seen twice in a row, the block locks. It then drives `os_factor = P/unit` and issues a one-cycle `ns_en` strobe once per unit, phase-aligned to the word clock. Any later disturbance clears the lock and measurement starts again.

The controller has four states. `ST_IDLE` is entered after reset and waits for the first word-clock fall. `ST_FIRST` waits for an acceptable period. `ST_CONFIRM` holds a candidate period. `ST_LOCKED` is the operating state. The transitions are:
- IDLE→FIRST on the first fall.
- FIRST→CONFIRM on an acceptable period.
- CONFIRM→LOCKED on an equal acceptable period.
- CONFIRM→CONFIRM (new candidate) on a different acceptable period.
- CONFIRM→FIRST on an unacceptable period.
- LOCKED→FIRST on a mismatch, a stall or a mode change.

Top module: `os_ratio_detector`

## Requirements
- R1: While reset is low, and afterwards until lock, `locked`, `os_factor` and `ns_en` are all 0.
- R2: With `undiv_sel`=1 the unit is 8 system clocks; with `undiv_sel`=0 (halved clock) the unit is 16 system clocks.
- R3: A period P (system clocks between successive word-clock falls) is acceptable only if P is a multiple of the unit and P/unit lies in 2..12 when `in_os4`=0, or 4..24 when `in_os4`=1; other periods never produce lock.
- R4: `locked` rises on the cycle after the fall that ends the second of two consecutive equal acceptable periods, and not earlier.
- R5: While locked, a fall ending a period that differs from the locked period clears `locked` on the next cycle; two new equal acceptable periods are then needed to lock again.
- R6: While locked, `os_factor` equals P/unit; while unlocked it is 0.
- R7: While locked, `ns_en` is high for exactly one cycle in each cycle j (j = 1 in the cycle after a fall) where j is a multiple of the unit, giving `os_factor` strobes per word period.
- R8: `ns_en` stays 0 whenever `locked` is 0.
- R9: While locked, if the count since the last fall reaches the locked period with no fall in that cycle, `locked` clears on the next cycle.
- R10: While locked, any change of `undiv_sel` or `in_os4` from the values held at lock clears `locked` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wck_sync | input | 1 | Word clock, already synchronized to `clk` |
| undiv_sel | input | 1 | 1: system clock undivided; 0: halved |
| in_os4 | input | 1 | 1: input is 4x oversampled; 0: 8x |
| os_factor | output | 5 | Locked oversampling factor n, 0 when unlocked |
| ns_en | output | 1 | Noise-shaper rate strobe |
| locked | output | 1 | Ratio measured and stable |

## Verification
Directed word-clock trains with periods of 48, 56 and 64 clocks show that lock and factor follow the measured ratio in both prescaler settings. Periods of 50, 8, 200 and 24 clocks are rejected, while 160 clocks is accepted in 4x mode; together these separate the multiple-of-unit test from the range test in each input mode. A period change, a stalled word clock and a pin change while locked each exercise one distinct unlock path. Seeded random sequences then mix modes, factors, repeat counts and one-clock period jitter, and every cycle is compared against a bench model built from the requirements.

// File: rtl/osr_pkg.sv
package osr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_CONFIRM,
        ST_LOCKED
    } osr_state_t;

    typedef struct packed {
        logic undiv;
        logic os4;
    } osr_mode_t;
endpackage

// File: rtl/osr_period_meter.sv
module osr_period_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wck,
    output logic             fall,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             wck_q;
    logic [CNT_W-1:0] cnt_q;

    assign fall  = wck_q & ~wck;
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wck_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            wck_q <= wck;
            if (fall)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // a new measurement window always starts at one (R4)
    assert_window_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (count == CNT_W'(1)));
endmodule

// File: rtl/osr_lock_fsm.sv
module osr_lock_fsm
    import osr_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int N_W      = 5,
    parameter int NMIN     = 2,
    parameter int NMAX     = 12,
    parameter int PULSE_SH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic [CNT_W-1:0] count,
    input  logic             undiv,
    input  logic             os4,
    output logic             locked,
    output logic [N_W-1:0]   n_out,
    output logic             en_allow
);
    localparam logic [CNT_W-1:0] MASK_U = CNT_W'((1 << PULSE_SH) - 1);
    localparam logic [CNT_W-1:0] MASK_D = CNT_W'((1 << (PULSE_SH + 1)) - 1);
    localparam logic [CNT_W-1:0] LO_8X  = CNT_W'(NMIN);
    localparam logic [CNT_W-1:0] HI_8X  = CNT_W'(NMAX);
    localparam logic [CNT_W-1:0] LO_4X  = CNT_W'(2 * NMIN);
    localparam logic [CNT_W-1:0] HI_4X  = CNT_W'(2 * NMAX);

    osr_state_t       st_q, st_nx;
    logic [CNT_W-1:0] ref_q;
    logic [N_W-1:0]   n_q;
    osr_mode_t        mode_q, mode_now;
    logic [CNT_W-1:0] n_meas, lo, hi;
    logic             frac_ok, period_ok, mode_same, load_ref, enter_lock;

    assign mode_now  = '{undiv: undiv, os4: os4};
    assign mode_same = (mode_now == mode_q);
    assign n_meas    = undiv ? (count >> PULSE_SH) : (count >> (PULSE_SH + 1));
    assign frac_ok   = undiv ? ((count & MASK_U) == '0) : ((count & MASK_D) == '0);
    assign lo        = os4 ? LO_4X : LO_8X;
    assign hi        = os4 ? HI_4X : HI_8X;
    assign period_ok = frac_ok && (n_meas >= lo) && (n_meas <= hi);

    // next-state selection
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (fall) st_nx = ST_FIRST;
            end
            ST_FIRST: begin
                if (fall && period_ok) st_nx = ST_CONFIRM;
            end
            ST_CONFIRM: begin
                if (fall) begin
                    if (!period_ok)          st_nx = ST_FIRST;
                    else if (count == ref_q) st_nx = ST_LOCKED;
                    else                     st_nx = ST_CONFIRM;
                end
            end
            ST_LOCKED: begin
                if (!mode_same)             st_nx = ST_FIRST;
                else if (fall)              st_nx = (count == ref_q) ? ST_LOCKED : ST_FIRST;
                else if (count >= ref_q)    st_nx = ST_FIRST;
            end
        endcase
    end

    assign load_ref   = fall && period_ok && ((st_q == ST_FIRST) || (st_q == ST_CONFIRM));
    assign enter_lock = (st_q == ST_CONFIRM) && (st_nx == ST_LOCKED);

    // state register and the values captured along with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ref_q  <= '0;
            n_q    <= '0;
            mode_q <= '0;
        end else begin
            st_q <= st_nx;
            if (load_ref)
                ref_q <= count;
            if (enter_lock) begin
                n_q    <= n_meas[N_W-1:0];
                mode_q <= mode_now;
            end
        end
    end

    // outputs
    always_comb begin
        locked   = (st_q == ST_LOCKED);
        n_out    = locked ? n_q : '0;
        en_allow = locked && mode_same;
    end

    assert_lock_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(fall));
    assert_factor_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ((n_out >= N_W'(NMIN)) && (n_out <= N_W'(2 * NMAX))));
    assert_unlock_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && fall && (count != ref_q)) |=> !locked);
    assert_unlock_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !fall && (count >= ref_q)) |=> !locked);
    assert_unlock_on_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ((undiv != mode_q.undiv) || (os4 != mode_q.os4))) |=> !locked);
endmodule

// File: rtl/osr_rate_gen.sv
module osr_rate_gen #(
    parameter int PULSE_SH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic undiv,
    input  logic allow,
    output logic ns_en
);
    logic                half_q;
    logic [PULSE_SH-1:0] tc_q;
    logic                tick;

    // internal clock enable: every cycle, or every second cycle when halved
    assign tick  = undiv | half_q;
    assign ns_en = allow & tick & (tc_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            tc_q   <= '0;
        end else if (restart) begin
            half_q <= 1'b0;
            tc_q   <= '0;
        end else begin
            half_q <= ~half_q;
            if (tick)
                tc_q <= tc_q + PULSE_SH'(1);
        end
    end
endmodule

// File: rtl/os_ratio_detector.sv
module os_ratio_detector #(
    parameter int NMIN     = 2,
    parameter int NMAX     = 12,
    parameter int PULSE_SH = 3,
    parameter int N_W      = $clog2(2 * NMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wck_sync,
    input  logic           undiv_sel,
    input  logic           in_os4,
    output logic [N_W-1:0] os_factor,
    output logic           ns_en,
    output logic           locked
);
    localparam int CNT_W = $clog2((2 * NMAX) << (PULSE_SH + 1)) + 1;

    logic             fall;
    logic [CNT_W-1:0] count;
    logic             en_allow;

    osr_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .wck   (wck_sync),
        .fall  (fall),
        .count (count)
    );

    osr_lock_fsm #(
        .CNT_W    (CNT_W),
        .N_W      (N_W),
        .NMIN     (NMIN),
        .NMAX     (NMAX),
        .PULSE_SH (PULSE_SH)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (fall),
        .count    (count),
        .undiv    (undiv_sel),
        .os4      (in_os4),
        .locked   (locked),
        .n_out    (os_factor),
        .en_allow (en_allow)
    );

    osr_rate_gen #(.PULSE_SH(PULSE_SH)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fall),
        .undiv   (undiv_sel),
        .allow   (en_allow),
        .ns_en   (ns_en)
    );

    assert_strobe_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ns_en |-> locked);
    assert_factor_zero_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (os_factor == '0));
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ns_en |=> !ns_en);
endmodule

// File: tb/os_ratio_detector_test.sv
module os_ratio_detector_test;
    localparam int CMAX = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wck = 1'b0;
    logic       undiv = 1'b1;
    logic       os4 = 1'b0;
    logic [4:0] os_factor;
    logic       ns_en;
    logic       locked;

    int nvec = 0;
    int nfail = 0;
    int pulses = 0;

    // reference model state
    int m_st = 0, m_cnt = 0, m_ref = 0, m_n = 0, m_mu = 0, m_m4 = 0, m_wq = 0;

    always #10 clk = ~clk;

    os_ratio_detector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wck_sync  (wck),
        .undiv_sel (undiv),
        .in_os4    (os4),
        .os_factor (os_factor),
        .ns_en     (ns_en),
        .locked    (locked)
    );

    function automatic int unit_of(input bit u);
        return u ? 8 : 16;
    endfunction

    function automatic bit per_ok(input int p, input bit u, input bit o4);
        int un, nn, lo, hi;
        un = unit_of(u);
        if (p % un != 0) return 1'b0;
        nn = p / un;
        lo = o4 ? 4 : 2;
        hi = o4 ? 24 : 12;
        return (nn >= lo) && (nn <= hi);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    // per-cycle comparison against the model, then model step
    always @(negedge clk) begin
        if (ns_en) pulses++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ref = 0; m_n = 0; m_mu = 0; m_m4 = 0; m_wq = 0;
            chk("R1 locked in reset", locked, 0);
            chk("R1 factor in reset", os_factor, 0);
            chk("R1 strobe in reset", ns_en, 0);
        end else begin
            int un, nst;
            bit fl, lk, same, e_en;
            un   = unit_of(undiv);
            lk   = (m_st == 3);
            same = (undiv == m_mu[0]) && (os4 == m_m4[0]);
            e_en = lk && same && (m_cnt % un == 0);
            chk("R4 locked", locked, lk);
            chk("R6 factor", os_factor, lk ? m_n : 0);
            chk(lk ? "R7 strobe" : "R8 strobe", ns_en, e_en);
            fl  = (m_wq == 1) && !wck;
            nst = m_st;
            case (m_st)
                0: if (fl) nst = 1;
                1: if (fl && per_ok(m_cnt, undiv, os4)) begin nst = 2; m_ref = m_cnt; end
                2: if (fl) begin
                       if (!per_ok(m_cnt, undiv, os4)) nst = 1;
                       else if (m_cnt == m_ref) begin
                           nst = 3; m_n = m_cnt / un; m_mu = undiv; m_m4 = os4;
                       end else m_ref = m_cnt;
                   end
                default: begin
                    if (!same) nst = 1;
                    else if (fl) begin if (m_cnt != m_ref) nst = 1; end
                    else if (m_cnt >= m_ref) nst = 1;
                end
            endcase
            m_st  = nst;
            m_cnt = fl ? 1 : ((m_cnt == CMAX) ? m_cnt : m_cnt + 1);
            m_wq  = wck;
        end
    end

    task automatic word(input int p);
        wck = 1'b1;
        repeat (p / 2) @(posedge clk);
        #1 wck = 1'b0;
        repeat (p - p / 2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog: actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5865));
        repeat (4) @(posedge clk);
        #1;
        chk("R1 locked after reset", locked, 0);
        chk("R1 factor after reset", os_factor, 0);
        rst_n = 1'b1;

        // R4: two equal 48-clock periods, undivided, 8x
        undiv = 1'b1; os4 = 1'b0;
        word(48); word(48);
        chk("R4 not locked after one period", locked, 0);
        word(48);
        chk("R4 locked", locked, 1);
        chk("R6 factor 48/8", os_factor, 6);
        pulses = 0; word(48);
        chk("R7 strobes per period", pulses, 6);

        // R5: period change drops lock, relock at 56
        word(56);
        chk("R5 unlocked after change", locked, 0);
        word(56); word(56);
        chk("R5 relocked", locked, 1);
        chk("R5 new factor", os_factor, 7);

        // R10: prescaler pin change while locked
        undiv = 1'b0;
        @(posedge clk); #1;
        chk("R10 unlocked on pin change", locked, 0);

        // R2: halved clock, unit 16
        word(64); word(64); word(64);
        chk("R2 locked halved", locked, 1);
        chk("R2 factor 64/16", os_factor, 4);
        pulses = 0; word(64);
        chk("R2 strobes halved", pulses, 4);

        // R3: rejected periods
        undiv = 1'b1;
        repeat (4) word(50);
        chk("R3 non-multiple rejected", locked, 0);
        repeat (4) word(8);
        chk("R3 below range rejected", locked, 0);
        repeat (4) word(200);
        chk("R3 above range rejected", locked, 0);
        os4 = 1'b1;
        repeat (4) word(24);
        chk("R3 below 4x range rejected", locked, 0);
        repeat (4) word(160);
        chk("R3 4x range accepted", locked, 1);
        chk("R3 4x factor", os_factor, 20);

        // R9: stalled word clock
        os4 = 1'b0;
        repeat (4) word(48);
        chk("R9 locked before stall", locked, 1);
        wck = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        chk("R9 unlocked on stall", locked, 0);
        pulses = 0;
        repeat (40) @(posedge clk);
        #1;
        chk("R8 no strobes unlocked", pulses, 0);

        // seeded random mixes
        for (int it = 0; it < 40; it++) begin
            int base, nsel, p, reps;
            undiv = 1'($urandom % 2);
            os4   = 1'($urandom % 2);
            nsel  = $urandom % 6;
            case (nsel)
                0: base = 2; 1: base = 3; 2: base = 4;
                3: base = 6; 4: base = 8; default: base = 12;
            endcase
            if (os4) base = base * 2;
            p    = base * unit_of(undiv);
            reps = 2 + ($urandom % 4);
            for (int r = 0; r < reps; r++) begin
                if ($urandom % 6 == 0) word(p + 1);
                else word(p);
            end
        end

        summary();
        $finish;
    end
endmodule